// File: doc/BRIEF.md
# SerDes Mode and Direction Controller

This block sits beside a bidirectional 24-bit serializer/deserializer port. It turns two range-select inputs and one direction input into the control set of the port: a power-down flag, a core reset, the PLL enable, separate serializer and deserializer enables, output enables for the parallel and serial drivers, a force-inputs-valid flag, and a 2-bit reference range code. A direction output carries the inverse of the direction input with no clocking, so that it can drive the direction input of a partner device in a master/slave pair.

Both selects low means power-down. In that state the reference-clock presence detector stays armed. The port leaves power-down only when a select is high and the reference has been seen as present. It then holds the core in reset for a fixed number of core cycles before it enables either direction. While the port acts as deserializer, a hold register captures the recovered parallel word. When the port turns to serializer, the register keeps its last word.

Top module: `serdes_mode_ctrl`

## Requirements
- R1: `range_code` equals {`sel_hi`,`sel_lo`} (01 = 2–5 MHz, 10 = 5–15 MHz, 11 = 10–20 MHz reference), and `link_active` is their OR. Both follow the inputs combinationally.
- R2: `dir_out` is the inverse of `dir_in` at all times and changes without any clock edge.
- R3: While powered down, `pll_en`, `ser_en`, `des_en`, `par_out_oe` and `ser_out_oe` are 0 and `par_in_force` and `core_rst` are 1, whatever `dir_in` is.
- R4: `ref_ok` rises once 8 rising edges of `ref_in` (synchronised by two core flops) have been counted, with no gap of 16 core cycles between edges.
- R5: `ref_ok` and the edge count clear when 16 core cycles pass with no reference edge.
- R6: `pwr_down` is set in the cycle after both selects are low. It clears only in the cycle after a select is high while `ref_ok` is 1. Without `ref_ok` it stays set.
- R7: After leaving power-down, `core_rst` stays 1 for exactly 4 cycles with `pll_en` at 1 and both directions disabled. Dropping the selects during this time returns the block to power-down.
- R8: Once out of reset, `dir_in`=1 gives `ser_en`=`ser_out_oe`=1, and `dir_in`=0 gives `des_en`=`par_out_oe`=1. The two are never active together.
- R9: `par_data` loads `des_data` on each cycle with the deserializer enabled, keeps its value otherwise, and clears to 0 in power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running core clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_hi | input | 1 | Upper range/mode select |
| sel_lo | input | 1 | Lower range/mode select |
| dir_in | input | 1 | 1 = serialize, 0 = deserialize |
| ref_in | input | 1 | Reference clock, asynchronous to clk |
| des_data | input | 24 | Recovered parallel word from the deserializer |
| dir_out | output | 1 | Inverted direction for the partner device |
| range_code | output | 2 | Reference range code |
| link_active | output | 1 | Either select high |
| ref_ok | output | 1 | Reference present |
| pwr_down | output | 1 | Power-down state |
| core_rst | output | 1 | Core reset request |
| pll_en | output | 1 | PLL enable |
| ser_en | output | 1 | Serializer enable |
| des_en | output | 1 | Deserializer enable |
| ser_out_oe | output | 1 | Serial driver enable |
| par_out_oe | output | 1 | Parallel output driver enable |
| par_in_force | output | 1 | Hold parallel inputs at a valid level |
| par_data | output | 24 | Held parallel output word |

## Verification
`range_code`, `link_active` and `dir_out` follow their inputs in the same cycle. The bench checks `dir_out` a fraction of a nanosecond after each direction change, between clock edges. A reference edge needs three core edges to reach the edge counter, so `ref_ok` rises three cycles after the eighth edge is sampled. The control state, and all enables decoded from it, change one edge after the select or `ref_ok` condition. `par_data` shows a captured word one edge after capture. A behavioural model in the bench advances on the same edges, and every output is compared against it at each falling edge, half a period after the design has settled.

// File: rtl/serdes_mode_pkg.sv
`timescale 1ns/1ps
package serdes_mode_pkg;

    localparam int DATA_W    = 24;
    localparam int EDGE_NEED = 8;
    localparam int GAP_LIMIT = 16;
    localparam int HOLD_CYC  = 4;

    typedef enum logic [1:0] {
        ST_PD   = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } pm_state_e;

    typedef struct packed {
        logic pwr_down;
        logic core_rst;
        logic pll_en;
        logic ser_en;
        logic des_en;
        logic ser_out_oe;
        logic par_out_oe;
        logic par_in_force;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(pm_state_e st, logic dir);
        ctrl_t c;
        c.pwr_down     = (st == ST_PD);
        c.core_rst     = (st != ST_RUN);
        c.pll_en       = (st != ST_PD);
        c.ser_en       = (st == ST_RUN) &&  dir;
        c.des_en       = (st == ST_RUN) && !dir;
        c.ser_out_oe   = c.ser_en;
        c.par_out_oe   = c.des_en;
        c.par_in_force = (st == ST_PD);
        return c;
    endfunction

endpackage

// File: rtl/ref_detect.sv
`timescale 1ns/1ps
module ref_detect #(
    parameter int EDGE_NEED = serdes_mode_pkg::EDGE_NEED,
    parameter int GAP_LIMIT = serdes_mode_pkg::GAP_LIMIT
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    output logic ref_ok
);
    localparam int EDGE_W = $clog2(EDGE_NEED + 1);
    localparam int GAP_W  = $clog2(GAP_LIMIT);

    logic [2:0]        sync_q;
    logic [EDGE_W-1:0] edge_cnt;
    logic [GAP_W-1:0]  gap_cnt;
    logic              rise;

    assign rise   = sync_q[1] && !sync_q[2];
    assign ref_ok = (edge_cnt == EDGE_W'(EDGE_NEED));

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '0;
            edge_cnt <= '0;
            gap_cnt  <= '0;
        end else begin
            sync_q <= {sync_q[1:0], ref_in};
            if (rise) begin
                gap_cnt <= '0;
                if (!ref_ok) edge_cnt <= edge_cnt + 1'b1;
            end else if (gap_cnt == GAP_W'(GAP_LIMIT - 1)) begin
                gap_cnt  <= '0;
                edge_cnt <= '0;
            end else begin
                gap_cnt <= gap_cnt + 1'b1;
            end
        end
    end

    // R4: presence is only ever declared on a counted edge
    a_r4_ok_on_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_ok) |-> $past(rise));

    // R5: a full silent window clears presence
    a_r5_gap_clears: assert property (@(posedge clk) disable iff (rst)
        (gap_cnt == GAP_W'(GAP_LIMIT - 1) && !rise) |=> !ref_ok);

endmodule

// File: rtl/mode_fsm.sv
`timescale 1ns/1ps
module mode_fsm
    import serdes_mode_pkg::*;
#(
    parameter int HOLD_CYC = serdes_mode_pkg::HOLD_CYC
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sel_any,
    input  logic      ref_ok,
    output pm_state_e state
);
    localparam int HC_W = $clog2(HOLD_CYC + 1);

    logic [HC_W-1:0] hcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_PD;
            hcnt  <= '0;
        end else begin
            case (state)
                ST_PD: begin
                    hcnt <= '0;
                    if (sel_any && ref_ok) state <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (!sel_any) begin
                        state <= ST_PD;
                    end else if (hcnt == HC_W'(HOLD_CYC - 1)) begin
                        state <= ST_RUN;
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (!sel_any) state <= ST_PD;
                end
                default: state <= ST_PD;
            endcase
        end
    end

    // R6: power-down is left only with a select high and a present reference
    a_r6_exit_needs_ref: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && $past(state) == ST_PD) |-> ($past(ref_ok) && $past(sel_any)));

    // R7: run is entered only at the end of the full reset hold
    a_r7_hold_len: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && $past(state) == ST_HOLD) |-> ($past(hcnt) == HC_W'(HOLD_CYC - 1)));

endmodule

// File: rtl/rx_hold.sv
`timescale 1ns/1ps
module rx_hold #(
    parameter int DATA_W = serdes_mode_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst || clear) dout <= '0;
        else if (load)    dout <= din;
    end

    // R9: without a load or clear the held word does not move
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (!load && !clear) |=> $stable(dout));

endmodule

// File: rtl/serdes_mode_ctrl.sv
`timescale 1ns/1ps
module serdes_mode_ctrl
    import serdes_mode_pkg::*;
#(
    parameter int DW        = serdes_mode_pkg::DATA_W,
    parameter int EDGES     = serdes_mode_pkg::EDGE_NEED,
    parameter int GAP_CYC   = serdes_mode_pkg::GAP_LIMIT,
    parameter int RST_CYC   = serdes_mode_pkg::HOLD_CYC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_hi,
    input  logic          sel_lo,
    input  logic          dir_in,
    input  logic          ref_in,
    input  logic [DW-1:0] des_data,
    output logic          dir_out,
    output logic [1:0]    range_code,
    output logic          link_active,
    output logic          ref_ok,
    output logic          pwr_down,
    output logic          core_rst,
    output logic          pll_en,
    output logic          ser_en,
    output logic          des_en,
    output logic          ser_out_oe,
    output logic          par_out_oe,
    output logic          par_in_force,
    output logic [DW-1:0] par_data
);
    pm_state_e state;
    ctrl_t     ctl;

    assign dir_out     = ~dir_in;
    assign range_code  = {sel_hi, sel_lo};
    assign link_active = sel_hi | sel_lo;

    ref_detect #(.EDGE_NEED(EDGES), .GAP_LIMIT(GAP_CYC)) u_ref (
        .clk    (clk),
        .rst    (rst),
        .ref_in (ref_in),
        .ref_ok (ref_ok)
    );

    mode_fsm #(.HOLD_CYC(RST_CYC)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .sel_any (link_active),
        .ref_ok  (ref_ok),
        .state   (state)
    );

    assign ctl          = decode_ctrl(state, dir_in);
    assign pwr_down     = ctl.pwr_down;
    assign core_rst     = ctl.core_rst;
    assign pll_en       = ctl.pll_en;
    assign ser_en       = ctl.ser_en;
    assign des_en       = ctl.des_en;
    assign ser_out_oe   = ctl.ser_out_oe;
    assign par_out_oe   = ctl.par_out_oe;
    assign par_in_force = ctl.par_in_force;

    rx_hold #(.DATA_W(DW)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .clear (pwr_down),
        .load  (des_en),
        .din   (des_data),
        .dout  (par_data)
    );

    // R3: nothing drives and the PLL is off while powered down
    a_r3_pd_quiet: assert property (@(posedge clk) disable iff (rst)
        pwr_down |-> (!pll_en && !ser_out_oe && !par_out_oe && par_in_force && core_rst));

    // R8: the two directions never drive together
    a_r8_one_driver: assert property (@(posedge clk) disable iff (rst)
        !(ser_out_oe && par_out_oe) && !(ser_en && des_en));

    // R6: leaving power-down needs a select high
    a_r6_pd_on_idle: assert property (@(posedge clk) disable iff (rst)
        !$past(link_active) |-> pwr_down);

endmodule

// File: tb/serdes_mode_ctrl_tb.sv
`timescale 1ns/1ps
module serdes_mode_ctrl_tb;
    localparam int DW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel_hi = 1'b0, sel_lo = 1'b0, dir_in = 1'b1, ref_in = 1'b0;
    logic [DW-1:0] des_data = '0;
    logic          dir_out, link_active, ref_ok, pwr_down, core_rst, pll_en;
    logic          ser_en, des_en, ser_out_oe, par_out_oe, par_in_force;
    logic [1:0]    range_code;
    logic [DW-1:0] par_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit ref_run = 1'b0;
    int ref_div = 0;

    serdes_mode_ctrl u_dut (
        .clk(clk), .rst(rst), .sel_hi(sel_hi), .sel_lo(sel_lo), .dir_in(dir_in),
        .ref_in(ref_in), .des_data(des_data), .dir_out(dir_out),
        .range_code(range_code), .link_active(link_active), .ref_ok(ref_ok),
        .pwr_down(pwr_down), .core_rst(core_rst), .pll_en(pll_en),
        .ser_en(ser_en), .des_en(des_en), .ser_out_oe(ser_out_oe),
        .par_out_oe(par_out_oe), .par_in_force(par_in_force), .par_data(par_data)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural model: sampled reference history, counters, state as integers
    int m_hist[$];
    int m_edges = 0, m_gap = 0, m_st = 0, m_hcnt = 0;
    longint m_par = 0;

    always @(posedge clk) begin
        int rise, ok, sel, nst, nh;
        longint npar;
        cyc++;
        if (rst) begin
            m_hist = {0, 0, 0};
            m_edges = 0; m_gap = 0; m_st = 0; m_hcnt = 0; m_par = 0;
        end else begin
            rise = (m_hist[1] == 1 && m_hist[2] == 0) ? 1 : 0;
            ok   = (m_edges == 8) ? 1 : 0;
            sel  = (sel_hi || sel_lo) ? 1 : 0;
            nst = m_st; nh = m_hcnt;
            if (m_st == 0) begin nh = 0; if (sel && ok) nst = 1; end
            else if (m_st == 1) begin
                if (!sel) nst = 0;
                else if (m_hcnt == 3) nst = 2;
                else nh = m_hcnt + 1;
            end else if (!sel) nst = 0;
            npar = m_par;
            if (m_st == 0) npar = 0;
            else if (m_st == 2 && !dir_in) npar = des_data;
            if (rise) begin m_gap = 0; if (m_edges < 8) m_edges++; end
            else if (m_gap == 15) begin m_gap = 0; m_edges = 0; end
            else m_gap++;
            m_hist.push_front(ref_in ? 1 : 0);
            void'(m_hist.pop_back());
            m_st = nst; m_hcnt = nh; m_par = npar;
        end
    end

    // compare every cycle, half a period after the edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R1", "range_code", range_code, {sel_hi, sel_lo});
            chk("R1", "link_active", link_active, sel_hi | sel_lo);
            chk("R2", "dir_out", dir_out, !dir_in);
            chk("R4/R5", "ref_ok", ref_ok, m_edges == 8);
            chk("R6", "pwr_down", pwr_down, m_st == 0);
            chk("R3", "pll_en", pll_en, m_st != 0);
            chk("R3", "par_in_force", par_in_force, m_st == 0);
            chk("R7", "core_rst", core_rst, m_st != 2);
            chk("R8", "ser_en", ser_en, m_st == 2 && dir_in);
            chk("R8", "ser_out_oe", ser_out_oe, m_st == 2 && dir_in);
            chk("R8", "des_en", des_en, m_st == 2 && !dir_in);
            chk("R8", "par_out_oe", par_out_oe, m_st == 2 && !dir_in);
            chk("R9", "par_data", par_data, m_par);
        end
    end

    // reference generator: rising edge every 6 core cycles when running
    always @(posedge clk) begin
        #1;
        if (ref_run) begin
            ref_div++;
            if (ref_div == 3) begin ref_div = 0; ref_in = ~ref_in; end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic flip_dir(input logic v);
        dir_in = v;
        #0.2;
        chk("R2", "dir_out async", dir_out, !v);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        #1;
        chk("R3", "reset pwr_down", pwr_down, 1);
        chk("R3", "reset pll_en", pll_en, 0);
        chk("R9", "reset par_data", par_data, 0);
        flip_dir(1'b0);
        flip_dir(1'b1);
        // R6: selects high but no reference: stays down
        sel_lo = 1'b1;
        step(40);
        chk("R6", "no ref stays down", pwr_down, 1);
        // R4: start reference, detect, exit, hold, run as serializer
        ref_run = 1'b1;
        step(80);
        chk("R4", "ref detected", ref_ok, 1);
        chk("R8", "serializer running", ser_en, 1);
        // R8/R9: turn to deserializer, capture words
        flip_dir(1'b0);
        for (int i = 0; i < 6; i++) begin
            des_data = 24'h5A0000 ^ (24'h111111 * i);
            step(1);
        end
        des_data = 24'hC3C3C3;
        step(2);
        chk("R9", "captured word", par_data, 24'hC3C3C3);
        // R9: back to serializer, word held while input changes
        flip_dir(1'b1);
        des_data = 24'h0F0F0F;
        step(5);
        chk("R9", "held word", par_data, 24'hC3C3C3);
        // R1: cycle through range codes while running
        sel_hi = 1'b1; sel_lo = 1'b0; step(3);
        sel_lo = 1'b1; step(3);
        chk("R1", "range 11", range_code, 2'b11);
        // R5: stop the reference; presence drops, link keeps running
        ref_run = 1'b0;
        step(30);
        chk("R5", "ref lost", ref_ok, 0);
        // R3: power down with dir both ways
        sel_hi = 1'b0; sel_lo = 1'b0; step(2);
        flip_dir(1'b0); step(2);
        chk("R3", "pd des off", des_en, 0);
        chk("R9", "pd clears word", par_data, 0);
        // R6: no reference, selects up, stays down
        sel_hi = 1'b1; step(20);
        chk("R6", "armed loss of ref", pwr_down, 1);
        // R7: restart reference, abort during reset hold
        ref_run = 1'b1;
        wait (pwr_down == 1'b0);
        step(1);
        sel_hi = 1'b0;
        step(2);
        chk("R7", "abort hold", pwr_down, 1);
        // full re-entry as deserializer
        sel_lo = 1'b1; des_data = 24'hABCDEF;
        step(10);
        chk("R8", "deserializer running", des_en, 1);
        step(3);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule